// File: doc/BRIEF.md
# Seven-to-one pixel lane serializer

The block turns one parallel pixel word per pixel clock into seven-bit frames on four single-ended data lanes plus a forward-clock lane. The word holds 25 general bits (24 colour bits and one general-purpose bit) together with the data-enable, vertical-sync and horizontal-sync controls. These 28 bits are spread over four lanes of seven slots each. The word is latched on the rising or the falling edge of the pixel clock, chosen by an input. The serializer runs on a bit clock seven times the pixel rate that is phase-related to it, as a PLL would supply it. The serializer takes in a new word at the first slot of every frame, so frames follow each other with no gap.

A differential output stage would sit behind the five lane outputs. While the active-low power-down input is low, all lanes are driven low and the internal frame state is cleared. Releasing power-down starts a fresh, aligned frame sequence.

Top module: `pixel_lane_serializer`

## Requirements
- R1: Lane 3 carries pix_bits_i[24:18] of a word, in descending bit order.
- R2: Lane 2 carries, in order, de_i, vs_i, hs_i, then pix_bits_i[17:14] in descending bit order.
- R3: Lane 1 carries pix_bits_i[13:7] and lane 0 carries pix_bits_i[6:0], each in descending bit order.
- R4: Each lane sends its slot 6 first and its slot 0 last, one slot per bit clock.
- R5: Every latched word is sent exactly once, in seven back-to-back slots per lane, with no idle slot between consecutive words.
- R6: The clock lane is high for 4 slots and low for 3 slots per word. Its rise starts slot 6 of the data lanes.
- R7: With edge_sel_i = 1 the word is latched on the rising pixel clock edge. With edge_sel_i = 0 it is latched on the falling edge, and the value present at the other edge has no effect.
- R8: While pd_ni is 0, every data and clock lane output is 0 at once and input words have no effect. After pd_ni returns to 1, words are again sent correctly framed.
- R9: While rst_ni is 0, all lane outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Bit-rate clock, seven slots per pixel clock period |
| pix_clk_i | input | 1 | Pixel clock, phase-related to bit_clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_ni | input | 1 | Active-low power-down |
| edge_sel_i | input | 1 | 1 latches on rising pixel edge, 0 on falling |
| pix_bits_i | input | 25 | Colour and general-purpose bits |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| lane_o | output | 4 | Serial data lanes, index equals lane number |
| clk_lane_o | output | 1 | Forward-clock lane |

## Verification
The hardest thing to show from the ports is which pixel clock edge actually latched the word. A plain word sequence comes out the same from either edge, only half a period later. The stimulus therefore drives the wanted word so that it is stable around the selected edge, and drives its bitwise complement around the other edge. A design that latches on the wrong edge then sends the complements. The same is done for both settings of edge_sel_i. Power-down is asserted part-way through a frame, so that a frame is cut short. After release, the framing recovered from the clock lane must lock again.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int unsigned PLS_LANES     = 4;
  localparam int unsigned PLS_SLOTS     = 7;
  localparam int unsigned PLS_CLK_HIGH  = 4;
  localparam int unsigned PLS_CTRL_LANE = 2;
  localparam int unsigned PLS_CTRL_W    = 3;

  typedef struct packed {
    logic de;
    logic vs;
    logic hs;
  } pls_ctrl_t;
endpackage

// File: rtl/pls_capture.sv
module pls_capture #(
  parameter int unsigned W = 28
) (
  input  logic         pix_clk_i,
  input  logic         rst_ni,
  input  logic         edge_sel_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] rise_q;
  logic [W-1:0] fall_q;

  always_ff @(posedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= d_i;
  end

  always_ff @(negedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= d_i;
  end

  // static select; both copies stay stable for a full pixel period
  assign q_o = edge_sel_i ? rise_q : fall_q;
endmodule

// File: rtl/pls_lane_map.sv
module pls_lane_map
  import pls_pkg::*;
#(
  parameter int unsigned LANES     = PLS_LANES,
  parameter int unsigned SLOTS     = PLS_SLOTS,
  parameter int unsigned CTRL_LANE = PLS_CTRL_LANE,
  localparam int unsigned WORD_W   = LANES * SLOTS,
  localparam int unsigned DATA_W   = WORD_W - PLS_CTRL_W
) (
  input  logic [DATA_W-1:0]            data_i,
  input  pls_ctrl_t                    ctrl_i,
  output logic [LANES-1:0][SLOTS-1:0]  lane_w_o
);
  // controls occupy the top slots of the control lane
  localparam int unsigned CTRL_LSB = CTRL_LANE * SLOTS + SLOTS - PLS_CTRL_W;

  logic [WORD_W-1:0] word;

  assign word[CTRL_LSB-1:0]                   = data_i[CTRL_LSB-1:0];
  assign word[CTRL_LSB+PLS_CTRL_W-1:CTRL_LSB] = {ctrl_i.de, ctrl_i.vs, ctrl_i.hs};

  generate
    if (CTRL_LANE < LANES - 1) begin : g_upper
      assign word[WORD_W-1:CTRL_LSB+PLS_CTRL_W] = data_i[DATA_W-1:CTRL_LSB];
    end
  endgenerate

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_w_o[l] = word[l*SLOTS +: SLOTS];
    end
  endgenerate
endmodule

// File: rtl/pls_shifter.sv
module pls_shifter
  import pls_pkg::*;
#(
  parameter int unsigned LANES    = PLS_LANES,
  parameter int unsigned SLOTS    = PLS_SLOTS,
  parameter int unsigned CLK_HIGH = PLS_CLK_HIGH,
  localparam int unsigned CNT_W   = $clog2(SLOTS),
  localparam int unsigned ROWS    = LANES + 1
) (
  input  logic                        bit_clk_i,
  input  logic                        rst_ni,
  input  logic                        pd_ni,
  input  logic [LANES-1:0][SLOTS-1:0] lane_w_i,
  output logic [LANES-1:0]            lane_o,
  output logic                        clk_lane_o
);
  localparam logic [SLOTS-1:0] CLK_PAT =
    SLOTS'(((1 << CLK_HIGH) - 1) << (SLOTS - CLK_HIGH));
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] HI_LAST   = CNT_W'(CLK_HIGH);

  logic [CNT_W-1:0]           cnt_q;
  logic                       load;
  logic [ROWS-1:0][SLOTS-1:0] load_w;
  logic [ROWS-1:0][SLOTS-1:0] sr_q;
  logic [LANES-1:0]           head;

  assign load = pd_ni && (cnt_q == '0);

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!pd_ni)             cnt_q <= '0;
    else if (cnt_q == LAST_SLOT) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // row LANES is the forward-clock lane
  assign load_w[LANES] = CLK_PAT;

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      if (r < LANES) begin : g_data
        assign load_w[r] = lane_w_i[r];
        assign head[r]   = lane_w_i[r][SLOTS-1];
      end
      always_ff @(posedge bit_clk_i or negedge rst_ni) begin
        if (!rst_ni)     sr_q[r] <= '0;
        else if (!pd_ni) sr_q[r] <= '0;
        else if (load)   sr_q[r] <= load_w[r];
        else             sr_q[r] <= {sr_q[r][SLOTS-2:0], 1'b0};
      end
      if (r < LANES) begin : g_out
        assign lane_o[r] = pd_ni & sr_q[r][SLOTS-1];
      end else begin : g_clk
        assign clk_lane_o = pd_ni & sr_q[r][SLOTS-1];
      end
    end
  endgenerate

  // R4
  first_slot_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    load |=> (!pd_ni || lane_o == $past(head)));

  // R6
  clk_high_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (pd_ni && cnt_q != '0 && cnt_q <= HI_LAST) |-> clk_lane_o);

  // R6
  clk_low_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (pd_ni && (cnt_q == '0 || cnt_q > HI_LAST)) |-> !clk_lane_o);

  // R8
  pd_realign_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    !pd_ni |=> (cnt_q == '0 && !clk_lane_o));

  // R5
  slot_range_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_SLOT);
endmodule

// File: rtl/pixel_lane_serializer.sv
module pixel_lane_serializer
  import pls_pkg::*;
#(
  parameter int unsigned LANES     = PLS_LANES,
  parameter int unsigned SLOTS     = PLS_SLOTS,
  parameter int unsigned CLK_HIGH  = PLS_CLK_HIGH,
  parameter int unsigned CTRL_LANE = PLS_CTRL_LANE,
  localparam int unsigned WORD_W   = LANES * SLOTS,
  localparam int unsigned DATA_W   = WORD_W - PLS_CTRL_W
) (
  input  logic              bit_clk_i,
  input  logic              pix_clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic              edge_sel_i,
  input  logic [DATA_W-1:0] pix_bits_i,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic              de_i,
  output logic [LANES-1:0]  lane_o,
  output logic              clk_lane_o
);
  logic [WORD_W-1:0]           cap_d;
  logic [WORD_W-1:0]           cap_q;
  pls_ctrl_t                   cap_ctrl;
  logic [LANES-1:0][SLOTS-1:0] lane_w;

  assign cap_d    = {de_i, vs_i, hs_i, pix_bits_i};
  assign cap_ctrl = pls_ctrl_t'(cap_q[WORD_W-1:DATA_W]);

  pls_capture #(.W(WORD_W)) i_capture (
    .pix_clk_i  (pix_clk_i),
    .rst_ni     (rst_ni),
    .edge_sel_i (edge_sel_i),
    .d_i        (cap_d),
    .q_o        (cap_q)
  );

  pls_lane_map #(.LANES(LANES), .SLOTS(SLOTS), .CTRL_LANE(CTRL_LANE)) i_lane_map (
    .data_i   (cap_q[DATA_W-1:0]),
    .ctrl_i   (cap_ctrl),
    .lane_w_o (lane_w)
  );

  pls_shifter #(.LANES(LANES), .SLOTS(SLOTS), .CLK_HIGH(CLK_HIGH)) i_shifter (
    .bit_clk_i  (bit_clk_i),
    .rst_ni     (rst_ni),
    .pd_ni      (pd_ni),
    .lane_w_i   (lane_w),
    .lane_o     (lane_o),
    .clk_lane_o (clk_lane_o)
  );
endmodule

// File: tb/test_pixel_lane_serializer.sv
`timescale 1ns/100ps
module test_pixel_lane_serializer;
  logic        bit_clk = 1'b0;
  logic        pix_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd_n = 1'b1;
  logic        edge_sel = 1'b1;
  logic [24:0] pix_bits = '0;
  logic        hs = 1'b0, vs = 1'b0, de = 1'b0;
  logic [3:0]  lanes;
  logic        clk_lane;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pixel_lane_serializer i_pixel_lane_serializer (
    .bit_clk_i(bit_clk), .pix_clk_i(pix_clk), .rst_ni(rst_n), .pd_ni(pd_n),
    .edge_sel_i(edge_sel), .pix_bits_i(pix_bits), .hs_i(hs), .vs_i(vs),
    .de_i(de), .lane_o(lanes), .clk_lane_o(clk_lane)
  );

  always #2.5 bit_clk = ~bit_clk;
  initial begin
    #1;
    forever begin
      pix_clk = 1'b1; #17.5;
      pix_clk = 1'b0; #17.5;
    end
  end

  // {de, vs, hs, pix_bits[24:0], expected lane-2 slots 6..0}
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 25'h1ABCDEF, 7'h4F},
    {1'b0, 1'b1, 1'b0, 25'h0000000, 7'h20},
    {1'b0, 1'b0, 1'b1, 25'h1FFFFFF, 7'h1F},
    {1'b1, 1'b1, 1'b1, 25'h0000000, 7'h70},
    {1'b0, 1'b0, 1'b0, 25'h0004000, 7'h01},
    {1'b0, 1'b0, 1'b0, 25'h0020000, 7'h08},
    {1'b1, 1'b0, 1'b1, 25'h1555555, 7'h55},
    {1'b0, 1'b1, 1'b0, 25'h0AAAAAA, 7'h2A},
    {1'b1, 1'b0, 1'b0, 25'h1000000, 7'h40},
    {1'b0, 1'b0, 1'b0, 25'h0000001, 7'h00},
    {1'b0, 1'b1, 1'b1, 25'h0123456, 7'h38},
    {1'b1, 1'b1, 1'b0, 25'h1FC0000, 7'h60}
  };

  // expected lane image {lane3, lane2, lane1, lane0}, slot 6 at the top of each
  function automatic logic [27:0] lane_image(input logic [27:0] s);
    return {s[24:18], s[27], s[26], s[25], s[17:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [27:0] act,
                       input logic [27:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // lane monitor: frames words from the clock-lane rise
  logic [27:0] rec [256];
  int          rec_n = 0;
  logic [3:0][6:0] cur;
  int          k = 0;
  logic        prev_clk = 1'b0;
  bit          armed = 1'b0;
  int          run = 0;
  int          clk_runs = 0;
  int          clk_bad = 0;

  always @(negedge bit_clk) begin
    if (!rst_n || !pd_n) begin
      armed = 1'b0; run = 0; prev_clk = 1'b0; k = 0;
    end else begin
      if (clk_lane && !prev_clk) begin
        cur = '0;
        for (int l = 0; l < 4; l++) cur[l][6] = lanes[l];
        k = 1;
      end else if (k > 0) begin
        for (int l = 0; l < 4; l++) cur[l][6-k] = lanes[l];
        k++;
        if (k == 7) begin
          if (rec_n < 256) begin
            rec[rec_n] = {cur[3], cur[2], cur[1], cur[0]};
            rec_n++;
          end
          k = 0;
        end
      end
      if (clk_lane != prev_clk) begin
        if (armed) begin
          if (prev_clk && run != 4) clk_bad++;
          if (!prev_clk && run != 3) clk_bad++;
          clk_runs++;
        end
        if (clk_lane) armed = 1'b1;
        run = 1;
      end else begin
        run++;
      end
      prev_clk = clk_lane;
    end
  end

  task automatic apply(input logic [27:0] s);
    {de, vs, hs, pix_bits} = s;
  endtask

  // wanted word stable at the selected edge, complement at the other
  task automatic drive_pair(input logic [27:0] good, input logic [27:0] decoy,
                            input bit rise_mode);
    if (rise_mode) begin
      @(negedge pix_clk); #2 apply(good);
      @(posedge pix_clk); #2 apply(decoy);
    end else begin
      @(posedge pix_clk); #2 apply(good);
      @(negedge pix_clk); #2 apply(decoy);
    end
  endtask

  task automatic run_walk(input bit rise_mode, input string tag);
    int base;
    int hit;
    logic [27:0] e;
    base = rec_n;
    hit = -1;
    edge_sel = rise_mode;
    repeat (2) drive_pair('0, '0, rise_mode);
    for (int i = 0; i < NV; i++) drive_pair(VEC[i][34:7], ~VEC[i][34:7], rise_mode);
    repeat (4) drive_pair('0, '0, rise_mode);
    repeat (30) @(posedge bit_clk);
    e = lane_image(VEC[0][34:7]);
    for (int j = base; j < rec_n; j++) if (hit < 0 && rec[j] == e) hit = j;
    check(hit >= 0 && hit + NV <= rec_n, {"R7 word found ", tag}, 28'(hit), e);
    if (hit >= 0 && hit + NV <= rec_n) begin
      for (int i = 0; i < NV; i++) begin
        e = lane_image(VEC[i][34:7]);
        check(rec[hit+i] == e, {"R1 R3 R4 R5 lanes ", tag}, rec[hit+i], e);
        check(rec[hit+i][20:14] == VEC[i][6:0], {"R2 lane2 ", tag},
              28'(rec[hit+i][20:14]), 28'(VEC[i][6:0]));
      end
    end
  endtask

  initial begin
    int bad;
    #20;
    check(lanes == 4'b0 && clk_lane == 1'b0, "R9 reset outputs",
          28'({lanes, clk_lane}), 28'h0);
    #13 rst_n = 1'b1;

    run_walk(1'b1, "rising");
    run_walk(1'b0, "falling");

    // power-down mid-frame
    edge_sel = 1'b1;
    repeat (3) @(posedge bit_clk);
    @(negedge bit_clk); #1 pd_n = 1'b0;
    #0.5;
    check(lanes == 4'b0 && clk_lane == 1'b0, "R8 immediate low",
          28'({lanes, clk_lane}), 28'h0);
    bad = 0;
    for (int i = 0; i < 21; i++) begin
      @(negedge bit_clk);
      if (lanes != 4'b0 || clk_lane != 1'b0) bad++;
      apply(28'(i * 32'h0135_79BD) ^ 28'hFFF_FFFF);
    end
    check(bad == 0, "R8 held low", 28'(bad), 28'h0);
    apply('0);
    @(negedge bit_clk); pd_n = 1'b1;

    run_walk(1'b1, "after power-down R8");

    check(clk_runs >= 20 && clk_bad == 0, "R6 clock lane 4 high 3 low",
          28'(clk_bad), 28'h0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule